// File: doc/BRIEF.md
# Bus-Master IDE DMA Channel

This block is one channel of a bus-master disk DMA controller. The host reaches it through an 8-byte I/O window and three registers: a command byte, a status byte and a 32-bit descriptor-table base address. The block decodes only the offset inside that window. By convention the primary channel's window sits at 0xC000 and the secondary channel's at 0xC008, and that decode lives outside the block. A start command in the device-to-memory direction makes the channel walk a table of 8-byte descriptors in memory. For each descriptor it copies the given number of bytes from the drive's sector-buffer stream to the given memory address.

Descriptors come in through a request/response read port. The request (`desc_req_valid`/`desc_req_ready`) holds its address until it is accepted. The response (`desc_rsp_valid`) has no back-pressure and must arrive in a later cycle. Payload bytes move from the `src_*` stream to the `mem_wr_*` stream with no storage in between:
- `mem_wr_valid` follows `src_valid` during a transfer.
- `src_ready` follows `mem_wr_ready`.
- A byte is consumed exactly when both are high.
- The source must hold its valid and data until they are taken.

On the descriptor flagged end-of-table, the channel updates its status. It pulses `tf_done` so the drive-side task file can drop busy, data-request and error and raise ready and seek-complete. It also pulses `irq` unless `irq_mask` is set.

Top module: `ide_busdma_chan`

## Requirements
- R1: After reset, the command, status and base registers read 0. `desc_req_valid`, `mem_wr_valid`, `tf_done` and `irq` are low.
- R2: Some accesses are rejected: offsets 1 and 3, a length of 0 or more than 4, a status access whose length is not 1, and a base access whose lane (offset minus 4) plus length exceeds 4. A rejected access raises `acc_err` in the same cycle, changes no register and returns 0.
- R3: Base bytes are addressed by lane, at offsets 4 to 7 (least significant byte at offset 4). A write of length L at lane n replaces bytes n to n+L-1 with `acc_wdata` bytes 0 to L-1, and a read returns them the same way.
- R4: A one-byte write at offset 2 replaces the whole status byte, and a read returns it.
- R5: A command write (offset 0) stores only bits 0 (start) and 3 (direction) of the written byte.
- R6: A command write with bit 0 and bit 3 set while the channel is idle sets status bit 0 (active) and then requests the descriptor at base + 8 × table index. The request address is held until it is accepted.
- R7: Descriptor bits 31:0 hold the target address, bits 32+CNT_W-1:32 the byte count and bit 63 the end-of-table flag. The channel writes that many source bytes, in order, to consecutive addresses starting at the target. The descriptor port and the write port are never active in the same cycle.
- R8: After the last byte of an end-of-table descriptor, status bits 0 (active) and 1 (error) clear and bit 2 (interrupt) sets. `tf_done` pulses for exactly one cycle, and `irq` pulses in that same cycle unless `irq_mask` is high.
- R9: The table index goes up by one after each finished descriptor, so a restart without clearing continues down the table. A command write with bit 0 clear resets the index to 0.
- R10: A command write with bit 0 set and bit 3 clear sets status bit 1 (error), leaves active clear and fetches nothing.
- R11: While `mem_wr_valid` is high and `mem_wr_ready` is low, the write address and data hold. No source byte is taken until `mem_wr_ready` is high.
- R12: A descriptor byte count of 0 transfers 2^CNT_W bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Host register write strobe |
| acc_rd | input | 1 | Host register read strobe |
| acc_off | input | 3 | Offset inside the 8-byte window |
| acc_len | input | 3 | Access length in bytes |
| acc_wdata | input | 32 | Write data, byte 0 first |
| acc_rdata | output | 32 | Read data, valid in the strobe cycle |
| acc_err | output | 1 | Access rejected |
| irq_mask | input | 1 | Suppresses the interrupt pulse |
| desc_req_valid | output | 1 | Descriptor fetch request |
| desc_req_ready | input | 1 | Fetch request accepted |
| desc_req_addr | output | 32 | Descriptor address |
| desc_rsp_valid | input | 1 | Descriptor data returned |
| desc_rsp_data | input | 64 | Descriptor contents |
| src_valid | input | 1 | Sector-buffer byte available |
| src_ready | output | 1 | Sector-buffer byte taken |
| src_data | input | 8 | Sector-buffer byte |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | 32 | Memory byte address |
| mem_wr_data | output | 8 | Memory write byte |
| tf_done | output | 1 | One-cycle completion pulse to the task file |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with CNT_W = 4 and IDX_W = 4. The 4-bit count makes a zero byte count mean 16 bytes, so the wrap case runs in a few dozen cycles instead of 65536. The 4-bit index keeps the descriptor table down to a handful of entries. A three-descriptor walk with a stalling memory sink then covers index advance, restart without clearing, index reset and the end-of-table status, all in short runs.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  // status bit positions
  localparam int ST_ACT = 0;
  localparam int ST_ERR = 1;
  localparam int ST_INT = 2;
  // command bit positions
  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  localparam logic [7:0] CMD_KEEP = 8'h09;
  // window offsets
  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;
  // descriptor layout
  localparam int DESC_W  = 64;
  localparam int EOT_BIT = 63;

  typedef enum logic [1:0] {WK_IDLE, WK_FETCH, WK_WAIT, WK_MOVE} wk_state_t;
endpackage

// File: rtl/ide_dma_regs.sv
module ide_dma_regs
  import ide_dma_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic [2:0]       acc_off,
  input  logic [2:0]       acc_len,
  input  logic [31:0]      acc_wdata,
  input  logic             eng_busy,
  input  logic             desc_adv,
  input  logic             xfer_fin,
  output logic [31:0]      acc_rdata,
  output logic             acc_err,
  output logic [31:0]      tbl_base,
  output logic [IDX_W-1:0] tbl_idx,
  output logic             launch
);
  logic [7:0]       cmd_q, stat_q, stat_nxt;
  logic [31:0]      base_q, base_nxt, base_rd;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       lane;
  logic [3:0]       lane_end;
  logic             len_ok, hit_cmd, hit_stat, hit_base, acc_ok;
  logic             cmd_wr, stat_wr, base_wr, go_bit, dir_bit;

  assign lane     = acc_off[1:0];
  assign lane_end = {2'b00, lane} + {1'b0, acc_len};
  assign len_ok   = (acc_len != 3'd0) && (acc_len <= 3'd4);
  assign hit_cmd  = (acc_off == OFF_CMD) && len_ok;
  assign hit_stat = (acc_off == OFF_STAT) && (acc_len == 3'd1);
  assign hit_base = acc_off[2] && len_ok && (lane_end <= 4'd4);
  assign acc_ok   = hit_cmd | hit_stat | hit_base;
  assign acc_err  = (acc_wr | acc_rd) & ~acc_ok;

  assign cmd_wr  = acc_wr & hit_cmd;
  assign stat_wr = acc_wr & hit_stat;
  assign base_wr = acc_wr & hit_base;
  assign go_bit  = acc_wdata[CMD_GO];
  assign dir_bit = acc_wdata[CMD_DIR];
  assign launch  = cmd_wr & go_bit & dir_bit & ~eng_busy;

  // byte-lane steering for the base register
  always_comb begin
    base_nxt = base_q;
    base_rd  = '0;
    for (int k = 0; k < 4; k++) begin
      int pos;
      pos = int'(lane) + k;
      if (k < int'(acc_len) && pos < 4) begin
        if (base_wr) base_nxt[8*pos +: 8] = acc_wdata[8*k +: 8];
        base_rd[8*k +: 8] = base_q[8*pos +: 8];
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (hit_cmd)       acc_rdata = {24'd0, cmd_q};
    else if (hit_stat) acc_rdata = {24'd0, stat_q};
    else if (hit_base) acc_rdata = base_rd;
  end

  always_comb begin
    stat_nxt = stat_q;
    if (stat_wr) stat_nxt = acc_wdata[7:0];
    if (cmd_wr && go_bit && !eng_busy) begin
      if (dir_bit) begin
        stat_nxt[ST_ACT] = 1'b1;
      end else begin
        stat_nxt[ST_ERR] = 1'b1;
        stat_nxt[ST_ACT] = 1'b0;
      end
    end
    if (xfer_fin) begin
      stat_nxt[ST_ACT] = 1'b0;
      stat_nxt[ST_ERR] = 1'b0;
      stat_nxt[ST_INT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      stat_q <= stat_nxt;
      base_q <= base_nxt;
      if (cmd_wr) cmd_q <= acc_wdata[7:0] & CMD_KEEP;
      if (cmd_wr && !go_bit) idx_q <= '0;
      else if (desc_adv)     idx_q <= idx_q + 1'b1;
    end
  end

  assign tbl_base = base_q;
  assign tbl_idx  = idx_q;
endmodule

// File: rtl/ide_dma_walker.sv
module ide_dma_walker
  import ide_dma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [31:0]       tbl_base,
  input  logic [IDX_W-1:0]  tbl_idx,
  output logic              busy,
  output logic              desc_adv,
  output logic              fin,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [DESC_W-1:0] rd_rsp_data,
  input  logic              buf_valid,
  output logic              buf_ready,
  input  logic [7:0]        buf_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_addr,
  output logic [7:0]        wr_data
);
  localparam int REM_W = CNT_W + 1;

  wk_state_t        st;
  logic [31:0]      cur_addr;
  logic [REM_W-1:0] remain;
  logic             eot_q, fin_q, move_hs, last_byte;
  logic [CNT_W-1:0] cnt_f;

  assign cnt_f        = rd_rsp_data[32 +: CNT_W];
  assign rd_addr      = tbl_base + ({{(32-IDX_W){1'b0}}, tbl_idx} << 3);
  assign rd_req_valid = (st == WK_FETCH);
  assign wr_valid     = (st == WK_MOVE) & buf_valid;
  assign buf_ready    = (st == WK_MOVE) & wr_ready;
  assign wr_addr      = cur_addr;
  assign wr_data      = buf_data;
  assign move_hs      = (st == WK_MOVE) & buf_valid & wr_ready;
  assign last_byte    = move_hs && (remain == REM_W'(1));
  assign desc_adv     = last_byte;
  assign busy         = (st != WK_IDLE);
  assign fin          = fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= WK_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      eot_q    <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (st)
        WK_IDLE:  if (launch) st <= WK_FETCH;
        WK_FETCH: if (rd_req_ready) st <= WK_WAIT;
        WK_WAIT:
          if (rd_rsp_valid) begin
            cur_addr <= rd_rsp_data[31:0];
            remain   <= (cnt_f == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_f};
            eot_q    <= rd_rsp_data[EOT_BIT];
            st       <= WK_MOVE;
          end
        WK_MOVE:
          if (move_hs) begin
            cur_addr <= cur_addr + 32'd1;
            remain   <= remain - REM_W'(1);
            if (last_byte) begin
              st    <= eot_q ? WK_IDLE : WK_FETCH;
              fin_q <= eot_q;
            end
          end
        default: st <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_busdma_chan.sv
module ide_busdma_chan
  import ide_dma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic [2:0]  acc_off,
  input  logic [2:0]  acc_len,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        acc_err,
  input  logic        irq_mask,
  output logic        desc_req_valid,
  input  logic        desc_req_ready,
  output logic [31:0] desc_req_addr,
  input  logic        desc_rsp_valid,
  input  logic [63:0] desc_rsp_data,
  input  logic        src_valid,
  output logic        src_ready,
  input  logic [7:0]  src_data,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [31:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        tf_done,
  output logic        irq
);
  logic [31:0]      tbl_base;
  logic [IDX_W-1:0] tbl_idx;
  logic             launch, busy, desc_adv, fin;

  ide_dma_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_off(acc_off), .acc_len(acc_len),
    .acc_wdata(acc_wdata), .eng_busy(busy), .desc_adv(desc_adv), .xfer_fin(fin),
    .acc_rdata(acc_rdata), .acc_err(acc_err),
    .tbl_base(tbl_base), .tbl_idx(tbl_idx), .launch(launch)
  );

  ide_dma_walker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .tbl_base(tbl_base), .tbl_idx(tbl_idx),
    .busy(busy), .desc_adv(desc_adv), .fin(fin),
    .rd_req_valid(desc_req_valid), .rd_req_ready(desc_req_ready), .rd_addr(desc_req_addr),
    .rd_rsp_valid(desc_rsp_valid), .rd_rsp_data(desc_rsp_data),
    .buf_valid(src_valid), .buf_ready(src_ready), .buf_data(src_data),
    .wr_valid(mem_wr_valid), .wr_ready(mem_wr_ready),
    .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
  );

  assign tf_done = fin;
  assign irq     = fin & ~irq_mask;
endmodule

// File: rtl/ide_busdma_chan_chk.sv
module ide_busdma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        desc_req_valid,
  input logic        desc_req_ready,
  input logic [31:0] desc_req_addr,
  input logic        mem_wr_valid,
  input logic        mem_wr_ready,
  input logic [31:0] mem_wr_addr,
  input logic [7:0]  mem_wr_data,
  input logic        tf_done,
  input logic        irq
);
  // R11
  mem_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid && !desc_req_ready |=> desc_req_valid && $stable(desc_req_addr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tf_done |=> !tf_done);

  // R8
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tf_done);

  // R7
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_req_valid, mem_wr_valid}));
endmodule

bind ide_busdma_chan ide_busdma_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .desc_req_valid(desc_req_valid), .desc_req_ready(desc_req_ready), .desc_req_addr(desc_req_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .tf_done(tf_done), .irq(irq)
);

// File: tb/ide_busdma_chan_bench.sv
module ide_busdma_chan_bench;
  localparam int CNT_W = 4;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [2:0]  acc_off = '0, acc_len = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err;
  logic        irq_mask = 1'b0;
  logic        desc_req_valid, desc_req_ready = 1'b1;
  logic [31:0] desc_req_addr;
  logic        desc_rsp_valid = 1'b0;
  logic [63:0] desc_rsp_data = '0;
  logic        src_valid = 1'b1, src_ready;
  logic [7:0]  src_data = 8'h30;
  logic        mem_wr_valid, mem_wr_ready = 1'b1;
  logic [31:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        tf_done, irq;

  ide_busdma_chan #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ide_busdma_chan (
    .clk(clk), .rst_n(rst_n),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_off(acc_off), .acc_len(acc_len),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
    .irq_mask(irq_mask),
    .desc_req_valid(desc_req_valid), .desc_req_ready(desc_req_ready), .desc_req_addr(desc_req_addr),
    .desc_rsp_valid(desc_rsp_valid), .desc_rsp_data(desc_rsp_data),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .tf_done(tf_done), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [63:0] dtab [0:15];
  logic [31:0] fetch_log [0:31];
  int          fetch_n = 0;
  logic [7:0]  wmem [0:255];
  int          wcount = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkd(input logic [31:0] a, input logic [15:0] c, input logic e);
    return {e, 15'd0, c, a};
  endfunction

  task automatic acc(input logic wr, input logic [2:0] off, input logic [2:0] len,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    acc_wr = wr; acc_rd = !wr; acc_off = off; acc_len = len; acc_wdata = wd;
    #1;
    rd = acc_rdata; er = acc_err;
    @(posedge clk);
    #1;
    acc_wr = 1'b0; acc_rd = 1'b0;
  endtask

  task automatic wait_done(output bit seen, output int irqs, output bit after);
    int t;
    t = 0; seen = 1'b0; irqs = 0;
    while (!seen && t < 3000) begin
      @(negedge clk); #1;
      t++;
      if (irq) irqs++;
      if (tf_done) seen = 1'b1;
    end
    @(negedge clk); #1;
    after = tf_done | irq;
  endtask

  // descriptor responder: one response the cycle after an accepted request
  initial begin
    bit pend;
    logic [31:0] paddr;
    pend = 1'b0; paddr = '0;
    forever begin
      @(negedge clk);
      desc_rsp_valid = pend;
      if (pend) desc_rsp_data = dtab[4'((paddr - 32'h100) >> 3)];
      pend = 1'b0;
      if (desc_req_valid && desc_req_ready) begin
        pend = 1'b1;
        paddr = desc_req_addr;
        if (fetch_n < 32) fetch_log[fetch_n] = desc_req_addr;
        fetch_n++;
      end
    end
  end

  // byte source and stalling memory sink
  initial begin
    int cyc;
    bit hs;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_wr_ready = ((cyc % 3) != 2);
      #1;
      hs = mem_wr_valid && mem_wr_ready;
      if (hs) begin
        wmem[mem_wr_addr[7:0]] = mem_wr_data;
        wcount++;
      end
      @(posedge clk);
      #1;
      if (hs) src_data = src_data + 8'd1;
    end
  end

  // fields: req[75:72] wr[71] off[70:68] len[67:65] wdata[64:33] exp[32:1] err[0]
  localparam int NV = 24;
  localparam logic [75:0] VEC [NV] = '{
    {4'd1,  1'b0, 3'd4, 3'd4, 32'h0,        32'h0,        1'b0}, // R1 base
    {4'd1,  1'b0, 3'd0, 3'd1, 32'h0,        32'h0,        1'b0}, // R1 cmd
    {4'd1,  1'b0, 3'd2, 3'd1, 32'h0,        32'h0,        1'b0}, // R1 status
    {4'd3,  1'b1, 3'd4, 3'd1, 32'hAB,       32'h0,        1'b0}, // R3
    {4'd3,  1'b1, 3'd6, 3'd2, 32'h1234,     32'h0,        1'b0}, // R3
    {4'd3,  1'b0, 3'd4, 3'd4, 32'h0,        32'h123400AB, 1'b0}, // R3
    {4'd3,  1'b0, 3'd5, 3'd2, 32'h0,        32'h3400,     1'b0}, // R3
    {4'd3,  1'b0, 3'd7, 3'd1, 32'h0,        32'h12,       1'b0}, // R3
    {4'd2,  1'b1, 3'd6, 3'd3, 32'hFFFFFF,   32'h0,        1'b1}, // R2 overrun
    {4'd2,  1'b0, 3'd7, 3'd2, 32'h0,        32'h0,        1'b1}, // R2 overrun
    {4'd2,  1'b1, 3'd1, 3'd1, 32'hFF,       32'h0,        1'b1}, // R2 offset 1
    {4'd2,  1'b0, 3'd3, 3'd1, 32'h0,        32'h0,        1'b1}, // R2 offset 3
    {4'd2,  1'b1, 3'd4, 3'd0, 32'h55,       32'h0,        1'b1}, // R2 zero length
    {4'd2,  1'b1, 3'd0, 3'd5, 32'h09,       32'h0,        1'b1}, // R2 long cmd
    {4'd2,  1'b0, 3'd4, 3'd4, 32'h0,        32'h123400AB, 1'b0}, // R2 untouched
    {4'd4,  1'b1, 3'd2, 3'd2, 32'h07,       32'h0,        1'b1}, // R4 two bytes
    {4'd4,  1'b1, 3'd2, 3'd1, 32'h06,       32'h0,        1'b0}, // R4
    {4'd4,  1'b0, 3'd2, 3'd1, 32'h0,        32'h06,       1'b0}, // R4
    {4'd4,  1'b1, 3'd2, 3'd1, 32'h00,       32'h0,        1'b0}, // R4
    {4'd5,  1'b1, 3'd0, 3'd1, 32'hFE,       32'h0,        1'b0}, // R5
    {4'd5,  1'b0, 3'd0, 3'd1, 32'h0,        32'h08,       1'b0}, // R5
    {4'd10, 1'b1, 3'd0, 3'd1, 32'h01,       32'h0,        1'b0}, // R10
    {4'd10, 1'b0, 3'd2, 3'd1, 32'h0,        32'h02,       1'b0}, // R10
    {4'd10, 1'b0, 3'd0, 3'd1, 32'h0,        32'h01,       1'b0}  // R10
  };

  initial begin
    logic [31:0] rd;
    logic        er;
    bit          seen, after;
    int          irqs, bad, n0;
    logic [7:0]  s0, e;

    for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
    for (int i = 0; i < 16; i++) dtab[i] = '0;

    repeat (3) @(negedge clk);
    #1;
    // R1 quiet outputs under and right after reset
    chk(!(desc_req_valid | mem_wr_valid | tf_done | irq), "R1 outputs idle",
        {28'd0, desc_req_valid, mem_wr_valid, tf_done, irq}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][71], VEC[i][70:68], VEC[i][67:65], VEC[i][64:33], rd, er);
      chk((er == VEC[i][0]) && (VEC[i][71] || rd == VEC[i][32:1]),
          $sformatf("R%0d vector %0d", VEC[i][75:72], i),
          VEC[i][71] ? {31'd0, er} : rd, VEC[i][71] ? {31'd0, VEC[i][0]} : VEC[i][32:1]);
    end
    repeat (4) @(negedge clk);
    chk(fetch_n == 0, "R10 no fetch", fetch_n, 0);

    // descriptor table at 0x100
    dtab[0] = mkd(32'h10, 16'd3, 1'b0);
    dtab[1] = mkd(32'h40, 16'd0, 1'b0);
    dtab[2] = mkd(32'h80, 16'd5, 1'b1);
    dtab[3] = mkd(32'hC0, 16'd2, 1'b1);
    acc(1'b1, 3'd4, 3'd4, 32'h100, rd, er);
    acc(1'b1, 3'd2, 3'd1, 32'h0, rd, er);
    acc(1'b1, 3'd0, 3'd1, 32'h0, rd, er);
    s0 = src_data;

    acc(1'b1, 3'd0, 3'd1, 32'h09, rd, er);
    acc(1'b0, 3'd2, 3'd1, 32'h0, rd, er);
    chk(rd == 32'h01, "R6 active set", rd, 32'h01);
    wait_done(seen, irqs, after);
    chk(seen, "R8 done pulse", {31'd0, seen}, 32'h1);
    chk(irqs == 1, "R8 irq pulse", irqs, 1);
    chk(!after, "R8 single cycle", {31'd0, after}, 32'h0);
    acc(1'b0, 3'd2, 3'd1, 32'h0, rd, er);
    chk(rd == 32'h04, "R8 final status", rd, 32'h04);
    acc(1'b0, 3'd0, 3'd1, 32'h0, rd, er);
    chk(rd == 32'h09, "R5 command kept", rd, 32'h09);
    chk(fetch_n == 3, "R6 fetch count", fetch_n, 3);
    for (int k = 0; k < 3; k++)
      chk(fetch_log[k] == 32'h100 + 32'(8 * k), "R6 R9 fetch address", fetch_log[k], 32'h100 + 32'(8 * k));
    chk(wcount == 24, "R7 byte count", wcount, 24);
    bad = 0; e = s0;
    for (int k = 0; k < 3; k++) begin if (wmem[8'h10 + 8'(k)] != e) bad++; e = e + 8'd1; end
    e = s0 + 8'd19;
    for (int k = 0; k < 5; k++) begin if (wmem[8'h80 + 8'(k)] != e) bad++; e = e + 8'd1; end
    chk(bad == 0, "R7 R11 payload under stalls", bad, 0);
    bad = 0; e = s0 + 8'd3;
    for (int k = 0; k < 16; k++) begin if (wmem[8'h40 + 8'(k)] != e) bad++; e = e + 8'd1; end
    if (wmem[8'h50] != 8'h00 || wmem[8'h3F] != 8'h00) bad++;
    chk(bad == 0, "R12 zero count wraps", bad, 0);

    // R9 restart without clearing continues at index 3
    n0 = fetch_n;
    acc(1'b1, 3'd0, 3'd1, 32'h09, rd, er);
    wait_done(seen, irqs, after);
    chk(fetch_log[n0] == 32'h118, "R9 index continues", fetch_log[n0], 32'h118);
    chk(wcount == 26, "R7 second run bytes", wcount, 26);

    // R9 clear then restart from index 0, with interrupt masked (R8)
    irq_mask = 1'b1;
    n0 = fetch_n;
    acc(1'b1, 3'd0, 3'd1, 32'h00, rd, er);
    acc(1'b1, 3'd0, 3'd1, 32'h09, rd, er);
    wait_done(seen, irqs, after);
    chk(fetch_log[n0] == 32'h100, "R9 index reset", fetch_log[n0], 32'h100);
    chk(seen && irqs == 0, "R8 masked irq", irqs, 0);
    acc(1'b0, 3'd2, 3'd1, 32'h0, rd, er);
    chk(rd == 32'h04, "R8 status after masked run", rd, 32'h04);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=hang expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule